// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller

This block collects interrupt requests for one processor and decides which of them may interrupt the code that is running. Each vector has a programmable 4-bit level. The controller holds a current level for the code now executing. It raises `irq_o` only when some pending vector has a level strictly above that current level. Vectors 0 to 7 are set and cleared by software through a register. Vector 8 and above come from level-sensitive peripheral lines.

Software reads the acknowledge register to take an interrupt. That read returns the winning vector, moves the current level up to the winner's level and saves the old level on a hardware stack. When the handler finishes, software writes the end-of-interrupt register. That write pops the stack and restores the level that was active before, so nested handlers unwind in reverse order. When several vectors share the top level, the lowest vector number wins. The order in which the requests arrived plays no part.

Top module: `nic_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some pending vector has a priority strictly greater than the current level. A vector at level 0 never interrupts, and neither does a vector at a level equal to or below the current level.
- R2: When several qualifying vectors share the highest pending level, the acknowledge read returns the smallest vector number among them.
- R3: A read of address 1 (acknowledge) while `irq_o` is 1 returns the winning vector number in `bus_rdata_o`. On that clock edge it sets the current level to the winner's priority and pushes the previous level onto the stack. The current level reads back zero-extended at address 0.
- R4: Each write to address 2 (end-of-interrupt) restores the level that was active before the most recent unmatched acknowledge. For example, levels 0, 1, 4 unwind as 4, 1, 0.
- R5: An end-of-interrupt write with an empty stack sets the current level to 0 and sets a sticky error flag. The flag is read as bit 0 of address 4 and stays set until reset.
- R6: Pending vectors are re-evaluated in the cycle after an end-of-interrupt write lowers the level. `irq_o` reasserts for a waiting vector that is now above the level.
- R7: A write to address 3 sets the software vectors whose bits are 1 in `bus_wdata_i[7:0]` and clears those whose bits are 1 in `bus_wdata_i[15:8]`. Clear wins if both are set. Peripheral line k is vector 8+k. It is sampled on each clock edge and stays pending only while the line is high.
- R8: An acknowledge read while `irq_o` is 0 returns the spurious code 0x00FF and leaves the current level and the stack unchanged.
- R9: The priority of vector v is read and written at address 16+v, in bits [3:0]. After reset all priorities, all software pending bits, the current level and the error flag are 0, and `irq_o` is 0.
- R10: `irq_o` falls in the cycle right after an acknowledge that raises the level to or above the best pending level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 8 | Level-sensitive peripheral request lines. Line k is vector 8+k |
| bus_addr_i | input | 6 | Register address |
| bus_wr_i | input | 1 | Write strobe. A write takes effect on the clock edge |
| bus_rd_i | input | 1 | Read strobe. It is ignored while `bus_wr_i` is high |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
On every cycle, the assertions check these properties:
- An acknowledge strictly raises the level.
- The returned vector is pending.
- An end-of-interrupt with a non-empty stack strictly lowers the level.
- An empty pop forces level 0 and the error flag, and the flag is sticky.
- A spurious acknowledge returns 0x00FF and holds the level.
- Nothing interrupts level 15.

Some behaviours are shown only by the bench's scenarios:
- Which vector wins a tie.
- That the exact saved level comes back on each pop.
- That requests waiting under a finished handler are served lowest vector first.
- The sweep over every vector and level pair for the strict-greater rule.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned N_SW        = 8;
  localparam int unsigned ADR_CUR     = 0;
  localparam int unsigned ADR_ACK     = 1;
  localparam int unsigned ADR_EOI     = 2;
  localparam int unsigned ADR_SWP     = 3;
  localparam int unsigned ADR_STAT    = 4;
  localparam int unsigned ADR_PRIO    = 16;
  localparam logic [15:0] SPURIOUS_VEC = 16'h00FF;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             pend_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0]            best_prio_o,
  output logic [VEC_W-1:0]             best_vec_o
);
  // ascending scan with strict compare: lowest vector keeps a tie
  always_comb begin
    best_prio_o = '0;
    best_vec_o  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (prio_i[i] > best_prio_o)) begin
        best_prio_o = prio_i[i];
        best_vec_o  = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = cnt_q - CNT_W'(1);
  assign top_o   = empty_o ? '0 : mem_q[top_idx[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[cnt_q[IDX_W-1:0]] <= data_i;
  end
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC       = 16,
  parameter int unsigned PRIO_W      = 4,
  parameter int unsigned STACK_DEPTH = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned N_PERIPH   = N_SRC - N_SW,
  localparam int unsigned VEC_W      = $clog2(N_SRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] irq_src_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);
  logic [PRIO_W-1:0]             cur_q;
  logic [N_SW-1:0]               sw_q;
  logic [N_PERIPH-1:0]           per_q;
  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic                          err_q;
  logic [N_SRC-1:0]              pend;
  logic [PRIO_W-1:0]             best_prio;
  logic [VEC_W-1:0]              best_vec;
  logic [PRIO_W-1:0]             stk_top;
  logic                          stk_empty;
  logic                          stk_full;
  logic                          rd_ack, take, eoi;
  logic [ADDR_W-1:0]             pidx;

  assign pend   = {per_q, sw_q};
  assign rd_ack = bus_rd_i && !bus_wr_i && (bus_addr_i == ADDR_W'(ADR_ACK));
  assign eoi    = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_EOI));
  assign irq_o  = best_prio > cur_q;
  assign take   = rd_ack && irq_o;

  nic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i      (pend),
    .prio_i      (prio_q),
    .best_prio_o (best_prio),
    .best_vec_o  (best_vec)
  );

  nic_prio_stack #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (take),
    .pop_i   (eoi),
    .data_i  (cur_q),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      err_q <= 1'b0;
      sw_q  <= '0;
      per_q <= '0;
    end else begin
      per_q <= irq_src_i;
      if (take) begin
        cur_q <= best_prio;
      end else if (eoi) begin
        cur_q <= stk_empty ? '0 : stk_top;
        if (stk_empty) err_q <= 1'b1;
      end
      if (bus_wr_i && bus_addr_i == ADDR_W'(ADR_SWP))
        sw_q <= (sw_q | bus_wdata_i[N_SW-1:0]) & ~bus_wdata_i[2*N_SW-1:N_SW];
    end
  end

  for (genvar v = 0; v < N_SRC; v++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[v] <= '0;
      else if (bus_wr_i && bus_addr_i == ADDR_W'(ADR_PRIO + v))
        prio_q[v] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  assign pidx = bus_addr_i - ADDR_W'(ADR_PRIO);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(ADR_CUR))       bus_rdata_o = DATA_W'(cur_q);
    else if (bus_addr_i == ADDR_W'(ADR_ACK))  bus_rdata_o = irq_o ? DATA_W'(best_vec) : SPURIOUS_VEC;
    else if (bus_addr_i == ADDR_W'(ADR_SWP))  bus_rdata_o = DATA_W'(sw_q);
    else if (bus_addr_i == ADDR_W'(ADR_STAT)) bus_rdata_o = DATA_W'(err_q);
    else if (bus_addr_i >= ADDR_W'(ADR_PRIO) && bus_addr_i < ADDR_W'(ADR_PRIO + N_SRC))
      bus_rdata_o = DATA_W'(prio_q[pidx[VEC_W-1:0]]);
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned VEC_W = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [PRIO_W-1:0] cur_q,
  input logic              err_q,
  input logic [N_SRC-1:0]  pend,
  input logic              stk_empty
);
  logic ack_rd, eoi_wr;
  assign ack_rd = bus_rd_i && !bus_wr_i && bus_addr_i == ADDR_W'(ADR_ACK);
  assign eoi_wr = bus_wr_i && bus_addr_i == ADDR_W'(ADR_EOI);

  AST_ACK_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd && irq_o |=> cur_q > $past(cur_q)); // R3
  AST_ACK_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd && irq_o |-> pend[bus_rdata_o[VEC_W-1:0]]); // R3
  AST_EOI_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr && !stk_empty |=> cur_q < $past(cur_q)); // R4
  AST_EOI_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr && stk_empty |=> cur_q == '0 && err_q); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R5
  AST_SPUR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd && !irq_o |-> bus_rdata_o == SPURIOUS_VEC); // R8
  AST_SPUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd && !irq_o |=> $stable(cur_q)); // R8
  AST_TOP_LEVEL_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q == {PRIO_W{1'b1}} |-> !irq_o); // R1
endmodule

bind nic_ctrl nic_checker #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cur_q       (cur_q),
  .err_q       (err_q),
  .pend        (pend),
  .stk_empty   (stk_empty)
);

// File: tb/nic_ctrl_tb_top.sv
module nic_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_src_i = '0;
  logic [5:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  nic_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bwr(int a, int d);
    @(negedge clk_i);
    bus_addr_i = 6'(a); bus_wdata_i = 16'(d); bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic brd(int a, output int r);
    @(negedge clk_i);
    bus_addr_i = 6'(a); bus_rd_i = 1'b1;
    #1 r = int'(bus_rdata_o);
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic set_pend(int v, bit on);
    if (v < 8) bwr(3, on ? (1 << v) : (256 << v));
    else begin
      @(negedge clk_i);
      irq_src_i[v-8] = on;
      @(negedge clk_i);
    end
  endtask

  task automatic cur_is(string req, int exp);
    int r;
    brd(0, r);
    chk(req, r, exp);
  endtask

  task automatic ack_is(string req, int exp);
    int r;
    brd(1, r);
    chk(req, r, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk("R9 irq", int'(irq_o), 0);
    cur_is("R9 cur", 0);
    brd(4, r); chk("R9 err", r, 0);
    brd(3, r); chk("R9 sw", r, 0);
    for (int v = 0; v < 16; v++) begin
      brd(16 + v, r); chk("R9 prio", r, 0);
    end

    // R8 spurious with nothing pending
    ack_is("R8 code", 255);
    cur_is("R8 hold", 0);

    // R1 R3 R10 R6 R7 sweep: every vector at every level
    for (int v = 0; v < 16; v++) begin
      set_pend(v, 1'b1);
      chk("R1 level0", int'(irq_o), 0);
      for (int p = 1; p < 16; p++) begin
        bwr(16 + v, p);
        chk("R1 raise", int'(irq_o), 1);
        ack_is("R3 vec", v);
        chk("R10 drop", int'(irq_o), 0);
        cur_is("R3 level", p);
        bwr(2, 0);
        cur_is("R4 back", 0);
        chk("R6 reeval", int'(irq_o), 1);
      end
      brd(16 + v, r); chk("R9 prio rb", r, 15);
      set_pend(v, 1'b0);
      chk("R7 clear", int'(irq_o), 0);
      bwr(16 + v, 0);
    end

    // R7 clear wins over set
    bwr(3, 16'h0101);
    brd(3, r); chk("R7 clr wins", r, 0);

    // R2 ties: all sixteen at level 3
    for (int v = 0; v < 16; v++) bwr(16 + v, 3);
    bwr(3, 16'h00FF);
    @(negedge clk_i); irq_src_i = 8'hFF; @(negedge clk_i);
    for (int k = 0; k < 16; k++) begin
      ack_is("R2 lowest", k);
      // R8: equal level is not above current
      ack_is("R8 equal", 255);
      cur_is("R8 hold", 3);
      bwr(2, 0);
      set_pend(k, 1'b0);
    end
    chk("R2 none", int'(irq_o), 0);
    for (int v = 0; v < 16; v++) bwr(16 + v, 0);

    // R4 R6 nested example: 9@1, 12@4, then 11@3 and 10@3
    bwr(16 + 9, 1); bwr(16 + 12, 4); bwr(16 + 11, 3); bwr(16 + 10, 3);
    set_pend(9, 1'b1);
    ack_is("R3 nest a", 9);  cur_is("R3 nest a", 1);
    set_pend(12, 1'b1);
    ack_is("R3 nest b", 12); cur_is("R3 nest b", 4);
    set_pend(11, 1'b1); set_pend(10, 1'b1);
    chk("R1 masked", int'(irq_o), 0);
    set_pend(12, 1'b0);
    bwr(2, 0); cur_is("R4 unwind", 1);
    chk("R6 reassert", int'(irq_o), 1);
    ack_is("R2 first", 10); cur_is("R3 lvl", 3);
    set_pend(10, 1'b0);
    bwr(2, 0); cur_is("R4 unwind", 1);
    ack_is("R6 second", 11);
    set_pend(11, 1'b0);
    bwr(2, 0); cur_is("R4 unwind", 1);
    set_pend(9, 1'b0);
    bwr(2, 0); cur_is("R4 unwind", 0);
    brd(4, r); chk("R5 no err", r, 0);

    // R4 deep nesting: vector v at level v, taken in ascending order
    for (int v = 1; v < 16; v++) bwr(16 + v, v);
    for (int v = 1; v < 16; v++) begin
      set_pend(v, 1'b1);
      ack_is("R3 deep", v);
    end
    cur_is("R3 deep top", 15);
    for (int v = 15; v >= 1; v--) begin
      set_pend(v, 1'b0);
      bwr(2, 0);
      cur_is("R4 deep", v - 1);
    end

    // R5 pop on empty
    bwr(2, 0);
    cur_is("R5 level", 0);
    brd(4, r); chk("R5 err", r, 1);
    bwr(16 + 2, 5); set_pend(2, 1'b1);
    ack_is("R5 after", 2);
    bwr(2, 0);
    brd(4, r); chk("R5 sticky", r, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule